// File: doc/BRIEF.md
# Programmable Data-Enable Generator

This block produces an active-video data-enable (DE) from a horizontal and a vertical sync stream. It is meant for sources that send sync pulses but no DE of their own. A pixel counter restarts on every HSYNC leading edge, and a line counter restarts on every VSYNC leading edge. Programmable offsets and spans then pick out a rectangular active window: a pixel offset, an active width, a line offset and an active line count.

For interlaced material, a field flag toggles on each VSYNC leading edge. While the flag is set, a small extra line offset is added, which accounts for the different blanking line count of alternate fields. A select input lets an externally supplied DE pass straight through in place of the generated one. Each sync input carries its own polarity control, so the edge logic always works on active-high pulses.

Top module: `de_synth`

## Requirements
- R1: With `use_gen` = 0, `de_out` equals `ext_de` in the same cycle, combinationally. With `use_gen` = 1, `de_out` is the generated DE.
- R2: A polarity input of 1 marks the matching sync as active low. The leading edge is the clock cycle in which the input first shows its active level after a cycle at the inactive level.
- R3: On an active line, the generated DE rises exactly `h_ofs`+2 cycles after the cycle that presents the HSYNC leading edge. It then stays high for exactly `de_width` consecutive cycles, unless another HSYNC leading edge restarts the count first.
- R4: A VSYNC leading edge sets the line number to 0. Each HSYNC leading edge increments it, and a VSYNC edge wins when both edges arrive in the same cycle. DE appears only on lines with number n where offset ≤ n < offset + `act_lines`. The stretch from a VSYNC edge to the next HSYNC edge is line 0, and it keeps the pixel count of the HSYNC that preceded it.
- R5: A field flag is 0 after reset and toggles on every VSYNC leading edge, so it is 1 in the first field after reset. While the flag is 1, the line offset is `v_ofs` + `il_adj`. While it is 0, the line offset is `v_ofs`.
- R6: A `de_width` of 0 or an `act_lines` of 0 keeps the generated DE low.
- R7: With `en` = 0, the generated DE is low from the next clock edge onward. The counters keep tracking the syncs, so DE resumes with correct timing as soon as `en` returns to 1.
- R8: After reset, the generated DE stays low until at least one HSYNC leading edge and one VSYNC leading edge have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables the generated DE |
| use_gen | input | 1 | 1 selects the generated DE, 0 selects `ext_de` |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| hs_low | input | 1 | 1 when `hs_in` is active low |
| vs_low | input | 1 | 1 when `vs_in` is active low |
| ext_de | input | 1 | External DE, passed through when `use_gen` = 0 |
| h_ofs | input | 10 | Pixel offset from the HSYNC leading edge to DE |
| v_ofs | input | 6 | Line offset from the VSYNC leading edge to the first active line |
| de_width | input | 12 | DE width in pixels |
| act_lines | input | 12 | Active lines per field |
| il_adj | input | 3 | Extra line offset applied in alternate fields |
| de_out | output | 1 | Data enable output |

## Verification
The embedded assertions check on every cycle that a high generated DE was enabled and had a non-zero width and line count one cycle earlier. They also check that it lay inside the pixel and line windows, and that the field flag changes only on a VSYNC leading edge. The exact rise cycle and pulse length, the line on which the window opens, and the alternating interlace offset can only be shown by the bench. So can polarity inversion, the partial line 0 when VSYNC arrives mid-line, and the external-DE bypass. The bench shows these by comparing `de_out` on every cycle with a behavioural model across frames built for each case.

// File: rtl/de_synth.sv
module de_synth #(
  parameter int HOFS_W = 10,
  parameter int VOFS_W = 6,
  parameter int SPAN_W = 12,
  parameter int ADJ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              use_gen,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              hs_low,
  input  logic              vs_low,
  input  logic              ext_de,
  input  logic [HOFS_W-1:0] h_ofs,
  input  logic [VOFS_W-1:0] v_ofs,
  input  logic [SPAN_W-1:0] de_width,
  input  logic [SPAN_W-1:0] act_lines,
  input  logic [ADJ_W-1:0]  il_adj,
  output logic              de_out
);
  localparam int CW = SPAN_W + 2;

  logic          hs_n, vs_n, hs_q, vs_q, hs_edge, vs_edge;
  logic [CW-1:0] px, ln, h_end, voff, v_end;
  logic          fld, h_act, v_act, de_q;

  assign hs_n    = hs_in ^ hs_low;
  assign vs_n    = vs_in ^ vs_low;
  assign hs_edge = hs_n & ~hs_q;
  assign vs_edge = vs_n & ~vs_q;

  assign h_end = CW'(h_ofs) + CW'(de_width);
  assign voff  = CW'(v_ofs) + (fld ? CW'(il_adj) : '0);
  assign v_end = voff + CW'(act_lines);
  assign h_act = (px >= CW'(h_ofs)) && (px < h_end);
  assign v_act = (ln >= voff) && (ln < v_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      px   <= '1;
      ln   <= '1;
      fld  <= 1'b0;
      de_q <= 1'b0;
    end else begin
      hs_q <= hs_n;
      vs_q <= vs_n;
      de_q <= en & h_act & v_act;
      if (hs_edge)      px <= '0;
      else if (~&px)    px <= px + 1'b1;
      if (vs_edge) begin
        ln  <= '0;
        fld <= ~fld;
      end else if (hs_edge && ~&ln) begin
        ln <= ln + 1'b1;
      end
    end
  end

  assign de_out = use_gen ? de_q : ext_de;

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> $past(en));
  // R6
  zero_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> ($past(de_width) != 0 && $past(act_lines) != 0));
  // R3
  px_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> ($past(px) >= CW'($past(h_ofs)) && $past(px) < $past(h_end)));
  // R4
  ln_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> ($past(ln) >= $past(voff) && $past(ln) < $past(v_end)));
  // R5
  fld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(fld));
endmodule

// File: tb/tb_de_synth.sv
module tb_de_synth;
  logic clk = 0, rst_n = 0, en = 0, use_gen = 1;
  logic hs_in = 0, vs_in = 0, hs_low = 0, vs_low = 0, ext_de = 0;
  logic [9:0]  h_ofs = 0;
  logic [5:0]  v_ofs = 0;
  logic [11:0] de_width = 0, act_lines = 0;
  logic [2:0]  il_adj = 0;
  logic        de_out;

  de_synth dut (.clk, .rst_n, .en, .use_gen, .hs_in, .vs_in, .hs_low, .vs_low,
                .ext_de, .h_ofs, .v_ofs, .de_width, .act_lines, .il_adj, .de_out);

  always #4 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  string req = "R8";

  // behavioural reference: integer pixel and line position, -1 = not yet seen
  int  m_px, m_ln;
  bit  m_fld, m_hp, m_vp, m_de;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_px = -1; m_ln = -1; m_fld = 0; m_hp = 0; m_vp = 0; m_de = 0;
    end else begin
      bit hn, vn, he, ve;
      int off;
      hn = hs_in ^ hs_low; vn = vs_in ^ vs_low;
      he = hn && !m_hp;    ve = vn && !m_vp;
      off = v_ofs + (m_fld ? il_adj : 0);
      m_de = en && m_px >= 0 && m_px >= h_ofs && m_px < h_ofs + de_width &&
             m_ln >= 0 && m_ln >= off && m_ln < off + act_lines;
      if (he) m_px = 0; else if (m_px >= 0) m_px++;
      if (ve) begin m_ln = 0; m_fld = !m_fld; end
      else if (he && m_ln >= 0) m_ln++;
      m_hp = hn; m_vp = vn;
    end
  end

  always @(negedge clk) begin
    bit exp_v;
    cycles++;
    exp_v = use_gen ? m_de : ext_de;
    vectors++;
    if (de_out !== exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d: de_out=%b expected %b", req, cycles, de_out, exp_v);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(bit h, bit v, bit rnd_ext);
    @(posedge clk); #2;
    hs_in = h ^ hs_low;
    vs_in = v ^ vs_low;
    if (rnd_ext) ext_de = $urandom_range(0, 1);
  endtask

  // vs_at: cycle within the frame where VSYNC goes active, vs_len its length in cycles
  task automatic frame(int lines, int ppl, int hsw, int vs_at, int vs_len, bit rnd_ext);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < ppl; p++) begin
        int t = l * ppl + p;
        step(p < hsw, t >= vs_at && t < vs_at + vs_len, rnd_ext);
      end
  endtask

  task automatic cfg(int ho, int w, int vo, int n, int adj);
    @(posedge clk); #2;
    h_ofs = ho; de_width = w; v_ofs = vo; act_lines = n; il_adj = adj;
  endtask

  initial begin
    req = "R8";
    repeat (3) @(posedge clk);
    #2 rst_n = 1; en = 1;
    cfg(2, 5, 0, 4, 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0);       // R8: no edges yet
    for (int i = 0; i < 3; i++) step(i < 2, 0, 0);   // R8: HS only

    req = "R3";
    cfg(5, 12, 3, 6, 0);
    frame(14, 40, 4, 0, 80, 0);
    frame(14, 40, 4, 0, 80, 0);
    cfg(0, 30, 1, 3, 0);                              // R3 zero pixel offset
    frame(10, 40, 3, 0, 40, 0);
    cfg(7, 40, 1, 3, 0);                              // R3 window cut by next HS
    frame(10, 40, 3, 0, 40, 0);

    req = "R4";
    cfg(3, 10, 0, 5, 0);
    frame(12, 36, 4, 50, 60, 0);                      // VSYNC mid-line, partial line 0
    frame(12, 36, 4, 50, 60, 0);
    cfg(4, 8, 2, 20, 0);                              // lines beyond frame end
    frame(10, 30, 2, 0, 30, 0);

    req = "R2";
    hs_low = 1; vs_low = 1;
    cfg(4, 9, 2, 5, 0);
    frame(12, 32, 5, 0, 64, 0);
    frame(12, 32, 5, 0, 64, 0);
    hs_low = 0; vs_low = 0;

    req = "R5";
    cfg(3, 10, 1, 4, 3);
    for (int f = 0; f < 4; f++) frame(12, 30, 3, 0, 30, 0);
    cfg(3, 10, 0, 2, 7);
    for (int f = 0; f < 3; f++) frame(12, 30, 3, 0, 30, 0);

    req = "R6";
    cfg(2, 0, 1, 5, 0);
    frame(10, 30, 3, 0, 30, 0);
    cfg(2, 10, 1, 0, 0);
    frame(10, 30, 3, 0, 30, 0);

    req = "R7";
    cfg(2, 10, 1, 6, 0);
    en = 0;
    frame(10, 30, 3, 0, 30, 0);
    fork
      frame(10, 30, 3, 0, 30, 0);
      begin repeat (95) @(posedge clk); #2 en = 1; repeat (60) @(posedge clk); #2 en = 0; end
    join
    en = 1;
    frame(10, 30, 3, 0, 30, 0);

    req = "R1";
    use_gen = 0;
    frame(10, 30, 3, 0, 30, 1);
    use_gen = 1;
    frame(10, 30, 3, 0, 30, 1);
    for (int i = 0; i < 40; i++) begin
      step(0, 0, 1);
      if (i % 7 == 0) use_gen = ~use_gen;
    end
    use_gen = 1;

    req = "R3";
    for (int k = 0; k < 4; k++) begin
      cfg($urandom_range(0, 15), $urandom_range(1, 25), $urandom_range(0, 4),
          $urandom_range(1, 8), $urandom_range(0, 7));
      frame(14, 44, $urandom_range(1, 6), $urandom_range(0, 100), 44, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule